// File: doc/BRIEF.md
# Segmented-Page Address Translator with Translation Cache

The block turns a 20-bit logical address into a 20-bit physical address. A logical address splits into a 4-bit segment number in bits 19:16, an 8-bit page number in bits 15:8 and an 8-bit word offset in bits 7:0. A physical address is a 12-bit block number in bits 19:8 followed by the unchanged word offset in bits 7:0. The segment number selects a descriptor in a 16-entry segment table. The descriptor holds a page-table base, a length in pages, an access-rights code and a valid flag. The base plus the page number addresses a 1024-entry page table, and each page-table entry supplies a block number and a present flag.

An 8-entry fully associative translation cache, keyed on the segment and page pair, keeps recent translations together with their rights code. A hit answers in one cycle with no table access. A miss runs a fixed two-step walk: the descriptor is read, then the page-table entry is read. The access then completes, and a successful walk installs the translation in the cache. Length, rights and presence are checked on every access. A violating access returns a fault code and an all-zero address. Software loads both tables through dedicated write ports. Any table write empties the cache.

Top module: `segpage_mmu`

## Requirements
- R1: While and right after `rst` is high, `busy` and `done` are low, `fault` is 0 and `phys_addr` is 0.
- R2: A successful access returns `phys_addr` = {block, word}. The word is `req_addr[7:0]`, and the block comes from the page-table entry at (segment base + `req_addr[15:8]`). The segment is selected by `req_addr[19:16]`.
- R3: A request accepted (`req_valid` high while `busy` is low) whose segment and page pair is cached gives `done` high on the next clock edge, with `busy` staying low.
- R4: A request that misses the cache raises `busy` on the next edge. `busy` stays high for two cycles, and `done` comes on the third edge after acceptance, together with the result.
- R5: The page-table address is (base + page) modulo 1024. Carries out of bit 9 are dropped.
- R6: When the page number is greater than or equal to the segment length, the access ends with `fault` = 1 (bounds) and `phys_addr` = 0.
- R7: Rights codes are 0 = any access, 1 = read only, 2 = fetch only, 3 = only with `req_sys` high. Access kinds are 0 = read, 1 = write, 2 = fetch, and 3 acts as a read. A denied access gives `fault` = 2 on both the hit path and the walk path.
- R8: An invalid segment or a non-present page gives `fault` = 3. Priority order is invalid segment, then bounds, then rights, then non-present page.
- R9: The cache holds 8 translations. A faulting access installs nothing. A new translation takes a free entry first, and otherwise replaces the least recently used one. Hits count as uses.
- R10: Any segment-table or page-table write empties the cache, so the next access to every pair walks the tables again and sees the new contents.
- R11: `req_valid` is ignored while `busy` is high. An in-flight walk's result is unaffected, and no extra `done` follows.
- R12: `done` is high for exactly one cycle per accepted request. `phys_addr` and `fault` read zero whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_addr | input | 20 | Logical address {segment, page, word} |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 as read |
| req_sys | input | 1 | Privileged access |
| seg_we | input | 1 | Segment descriptor write |
| seg_widx | input | 4 | Segment number to write |
| seg_wbase | input | 10 | Page-table base |
| seg_wlen | input | 9 | Segment length in pages (0 to 256) |
| seg_wrights | input | 2 | Rights code |
| seg_wvalid | input | 1 | Descriptor valid |
| pt_we | input | 1 | Page-table entry write |
| pt_waddr | input | 10 | Page-table address |
| pt_wblock | input | 12 | Block number |
| pt_wpresent | input | 1 | Page present |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | Result valid, one cycle |
| phys_addr | output | 20 | Physical address {block, word} |
| fault | output | 2 | 0 none, 1 bounds, 2 rights, 3 absent |

## Verification
A hit is due one edge after acceptance. A miss shows `busy` high for the two cycles after acceptance, and its result lands on the third edge. The bench holds a behavioural model of the tables and a recency-ordered list of cached pairs. This model decides hit or miss, and so the latency, for every request. All four outputs are compared on the falling edge of every cycle, so a result that arrives one cycle early or late is a mismatch in that cycle rather than a later surprise. Fault priority, modulo wrap of the page-table address, eviction order and the flush caused by table writes are all covered by the same model, and so are requests held on `req_valid` during a walk.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RT_FULL   = 2'd0,
    RT_RDONLY = 2'd1,
    RT_EXEC   = 2'd2,
    RT_SYS    = 2'd3
  } rights_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_RIGHTS = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  // Rights check shared by the hit path and the walk path.
  function automatic logic access_allowed(input logic [1:0] rt,
                                          input logic [1:0] kind,
                                          input logic       sys);
    logic ok;
    case (rights_e'(rt))
      RT_FULL:   ok = 1'b1;
      RT_RDONLY: ok = (kind == ACC_READ) || (kind == ACC_RSVD);
      RT_EXEC:   ok = (kind == ACC_FETCH);
      default:   ok = sys;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/segpage_tables.sv
module segpage_tables #(
  parameter int SEG_W = 4,
  parameter int PTA_W = 10,
  parameter int LEN_W = 9,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seg_we,
  input  logic [SEG_W-1:0] seg_wa,
  input  logic [PTA_W-1:0] seg_wbase,
  input  logic [LEN_W-1:0] seg_wlen,
  input  logic [1:0]       seg_wrt,
  input  logic             seg_wok,
  input  logic [SEG_W-1:0] seg_ra,
  output logic [PTA_W-1:0] seg_base_q,
  output logic [LEN_W-1:0] seg_len_q,
  output logic [1:0]       seg_rt_q,
  output logic             seg_ok_q,
  input  logic             pt_we,
  input  logic [PTA_W-1:0] pt_wa,
  input  logic [BLK_W-1:0] pt_wblk,
  input  logic             pt_wpres,
  input  logic [PTA_W-1:0] pt_ra,
  output logic [BLK_W-1:0] pt_blk_q,
  output logic             pt_pres_q
);
  localparam int NSEG = 1 << SEG_W;
  localparam int NPT  = 1 << PTA_W;

  logic [PTA_W-1:0] seg_base [NSEG];
  logic [LEN_W-1:0] seg_len  [NSEG];
  logic [1:0]       seg_rt   [NSEG];
  logic [NSEG-1:0]  seg_ok;

  logic [BLK_W:0]   pt_mem   [NPT];
  logic [BLK_W:0]   pt_q;

  // Descriptor fields: plain storage, no reset.
  always_ff @(posedge clk) begin
    if (seg_we) begin
      seg_base[seg_wa] <= seg_wbase;
      seg_len[seg_wa]  <= seg_wlen;
      seg_rt[seg_wa]   <= seg_wrt;
    end
    seg_base_q <= seg_base[seg_ra];
    seg_len_q  <= seg_len[seg_ra];
    seg_rt_q   <= seg_rt[seg_ra];
  end

  // Valid flags are cleared by reset so unloaded segments fault.
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_ok   <= '0;
      seg_ok_q <= 1'b0;
    end else begin
      if (seg_we) seg_ok[seg_wa] <= seg_wok;
      seg_ok_q <= seg_ok[seg_ra];
    end
  end

  // Page table: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (pt_we) pt_mem[pt_wa] <= {pt_wpres, pt_wblk};
    pt_q <= pt_mem[pt_ra];
  end

  assign pt_blk_q  = pt_q[BLK_W-1:0];
  assign pt_pres_q = pt_q[BLK_W];

endmodule

// File: rtl/segpage_tlb.sv
module segpage_tlb #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 12,
  parameter int BLK_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] lk_key,
  output logic             hit,
  output logic [BLK_W-1:0] hit_blk,
  output logic [1:0]       hit_rt,
  input  logic             touch_en,
  input  logic             fill_en,
  input  logic [KEY_W-1:0] fill_key,
  input  logic [BLK_W-1:0] fill_blk,
  input  logic [1:0]       fill_rt,
  input  logic             flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid;
  logic [KEY_W-1:0]   e_key [ENTRIES];
  logic [BLK_W-1:0]   e_blk [ENTRIES];
  logic [1:0]         e_rt  [ENTRIES];
  logic [IDX_W-1:0]   e_age [ENTRIES];

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, victim, use_idx;
  logic               use_en;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid[g] && (e_key[g] == lk_key);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit     = |match;
  assign hit_blk = e_blk[hit_idx];
  assign hit_rt  = e_rt[hit_idx];

  // Victim: lowest free entry, else the one whose age is the largest.
  always_comb begin
    logic             have_free;
    logic [IDX_W-1:0] vic_free, vic_old;
    have_free = 1'b0;
    vic_free  = '0;
    vic_old   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid[i] && !have_free) begin
        vic_free  = IDX_W'(i);
        have_free = 1'b1;
      end
      if (e_age[i] == OLDEST) vic_old = IDX_W'(i);
    end
    victim = have_free ? vic_free : vic_old;
  end

  assign use_en  = fill_en || touch_en;
  assign use_idx = fill_en ? victim : hit_idx;

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      e_key[victim] <= fill_key;
      e_blk[victim] <= fill_blk;
      e_rt[victim]  <= fill_rt;
    end
  end

  // Ages form a permutation of 0..ENTRIES-1; a use moves one entry to 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) e_age[i] <= IDX_W'(i);
    end else if (flush) begin
      valid <= '0;
    end else if (use_en) begin
      if (fill_en) valid[victim] <= 1'b1;
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == use_idx)          e_age[i] <= '0;
        else if (e_age[i] < e_age[use_idx]) e_age[i] <= e_age[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/segpage_mmu.sv
module segpage_mmu
  import segpage_pkg::*;
#(
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 8,
  parameter int WORD_W      = 8,
  parameter int BLK_W       = 12,
  parameter int PTA_W       = 10,
  parameter int TLB_ENTRIES = 8,
  localparam int LA_W  = SEG_W + PAGE_W + WORD_W,
  localparam int PA_W  = BLK_W + WORD_W,
  localparam int LEN_W = PAGE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LA_W-1:0]  req_addr,
  input  logic [1:0]       req_kind,
  input  logic             req_sys,
  input  logic             seg_we,
  input  logic [SEG_W-1:0] seg_widx,
  input  logic [PTA_W-1:0] seg_wbase,
  input  logic [LEN_W-1:0] seg_wlen,
  input  logic [1:0]       seg_wrights,
  input  logic             seg_wvalid,
  input  logic             pt_we,
  input  logic [PTA_W-1:0] pt_waddr,
  input  logic [BLK_W-1:0] pt_wblock,
  input  logic             pt_wpresent,
  output logic             busy,
  output logic             done,
  output logic [PA_W-1:0]  phys_addr,
  output logic [1:0]       fault
);
  localparam int KEY_W = SEG_W + PAGE_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SEG, ST_PT} walk_st_e;

  walk_st_e          st;
  logic              accept;
  logic [KEY_W-1:0]  lk_key;

  logic [SEG_W-1:0]  l_seg;
  logic [PAGE_W-1:0] l_page;
  logic [WORD_W-1:0] l_word;
  logic [1:0]        l_kind;
  logic              l_sys;
  logic [1:0]        l_rt;
  fault_e            pend;

  logic [PTA_W-1:0]  seg_base_q;
  logic [LEN_W-1:0]  seg_len_q;
  logic [1:0]        seg_rt_q;
  logic              seg_ok_q;
  logic [PTA_W-1:0]  pt_ra;
  logic [BLK_W-1:0]  pt_blk_q;
  logic              pt_pres_q;

  logic              tlb_hit;
  logic [BLK_W-1:0]  tlb_blk;
  logic [1:0]        tlb_rt;
  logic              fill_en;
  logic              hit_ok;
  fault_e            seg_chk;
  fault_e            final_f;

  assign accept = req_valid && (st == ST_IDLE);
  assign lk_key = req_addr[LA_W-1:WORD_W];
  assign pt_ra  = seg_base_q + PTA_W'(l_page);
  assign busy   = (st != ST_IDLE);

  segpage_tables #(
    .SEG_W(SEG_W), .PTA_W(PTA_W), .LEN_W(LEN_W), .BLK_W(BLK_W)
  ) u_tables (
    .clk       (clk),
    .rst       (rst),
    .seg_we    (seg_we),
    .seg_wa    (seg_widx),
    .seg_wbase (seg_wbase),
    .seg_wlen  (seg_wlen),
    .seg_wrt   (seg_wrights),
    .seg_wok   (seg_wvalid),
    .seg_ra    (req_addr[LA_W-1:LA_W-SEG_W]),
    .seg_base_q(seg_base_q),
    .seg_len_q (seg_len_q),
    .seg_rt_q  (seg_rt_q),
    .seg_ok_q  (seg_ok_q),
    .pt_we     (pt_we),
    .pt_wa     (pt_waddr),
    .pt_wblk   (pt_wblock),
    .pt_wpres  (pt_wpresent),
    .pt_ra     (pt_ra),
    .pt_blk_q  (pt_blk_q),
    .pt_pres_q (pt_pres_q)
  );

  segpage_tlb #(
    .ENTRIES(TLB_ENTRIES), .KEY_W(KEY_W), .BLK_W(BLK_W)
  ) u_tlb (
    .clk     (clk),
    .rst     (rst),
    .lk_key  (lk_key),
    .hit     (tlb_hit),
    .hit_blk (tlb_blk),
    .hit_rt  (tlb_rt),
    .touch_en(accept && tlb_hit),
    .fill_en (fill_en),
    .fill_key({l_seg, l_page}),
    .fill_blk(pt_blk_q),
    .fill_rt (l_rt),
    .flush   (seg_we || pt_we)
  );

  assign hit_ok = access_allowed(tlb_rt, req_kind, req_sys);

  // Descriptor checks, in priority order.
  always_comb begin
    if (!seg_ok_q)                           seg_chk = FLT_ABSENT;
    else if ({1'b0, l_page} >= seg_len_q)    seg_chk = FLT_BOUNDS;
    else if (!access_allowed(seg_rt_q, l_kind, l_sys)) seg_chk = FLT_RIGHTS;
    else                                     seg_chk = FLT_NONE;
  end

  always_comb begin
    if (pend != FLT_NONE) final_f = pend;
    else if (!pt_pres_q)  final_f = FLT_ABSENT;
    else                  final_f = FLT_NONE;
  end

  assign fill_en = (st == ST_PT) && (final_f == FLT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      phys_addr <= '0;
      fault     <= FLT_NONE;
      pend      <= FLT_NONE;
      l_seg     <= '0;
      l_page    <= '0;
      l_word    <= '0;
      l_kind    <= '0;
      l_sys     <= 1'b0;
      l_rt      <= '0;
    end else begin
      done      <= 1'b0;
      phys_addr <= '0;
      fault     <= FLT_NONE;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            l_seg  <= req_addr[LA_W-1:LA_W-SEG_W];
            l_page <= req_addr[WORD_W+PAGE_W-1:WORD_W];
            l_word <= req_addr[WORD_W-1:0];
            l_kind <= req_kind;
            l_sys  <= req_sys;
            if (tlb_hit) begin
              done <= 1'b1;
              if (hit_ok) phys_addr <= {tlb_blk, req_addr[WORD_W-1:0]};
              else        fault     <= FLT_RIGHTS;
            end else begin
              st <= ST_SEG;
            end
          end
        end
        ST_SEG: begin
          pend <= seg_chk;
          l_rt <= seg_rt_q;
          st   <= ST_PT;
        end
        default: begin
          done  <= 1'b1;
          fault <= final_f;
          if (final_f == FLT_NONE) phys_addr <= {pt_blk_q, l_word};
          st    <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/segpage_mmu_chk.sv
module segpage_mmu_chk #(
  parameter int WORD_W = 8,
  parameter int LA_W   = 20,
  parameter int PA_W   = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [LA_W-1:0] req_addr,
  input logic            busy,
  input logic            done,
  input logic [PA_W-1:0] phys_addr,
  input logic [1:0]      fault
);
  logic [WORD_W-1:0] last_word;

  always_ff @(posedge clk) begin
    if (rst)                    last_word <= '0;
    else if (req_valid && !busy) last_word <= req_addr[WORD_W-1:0];
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && fault == 2'd0));

  // R2
  word_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 2'd0) |-> phys_addr[WORD_W-1:0] == last_word);

  // R3
  accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (done || busy));

  // R4
  walk_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 (!busy && done));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R12
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (fault == 2'd0 && phys_addr == '0));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> phys_addr == '0);

endmodule

bind segpage_mmu segpage_mmu_chk #(
  .WORD_W(WORD_W), .LA_W(LA_W), .PA_W(PA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .busy     (busy),
  .done     (done),
  .phys_addr(phys_addr),
  .fault    (fault)
);

// File: tb/segpage_mmu_test.sv
module segpage_mmu_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [19:0] req_addr;
  logic [1:0]  req_kind;
  logic        req_sys;
  logic        seg_we;
  logic [3:0]  seg_widx;
  logic [9:0]  seg_wbase;
  logic [8:0]  seg_wlen;
  logic [1:0]  seg_wrights;
  logic        seg_wvalid;
  logic        pt_we;
  logic [9:0]  pt_waddr;
  logic [11:0] pt_wblock;
  logic        pt_wpresent;
  logic        busy, done;
  logic [19:0] phys_addr;
  logic [1:0]  fault;

  int n_cmp = 0;
  int n_bad = 0;

  bit [9:0]  m_base [16];
  bit [8:0]  m_len  [16];
  bit [1:0]  m_rt   [16];
  bit        m_ok   [16];
  bit [11:0] m_blk  [1024];
  bit        m_pres [1024];
  int        cached [$];

  always #5 clk = ~clk;

  segpage_mmu uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_sys(req_sys), .seg_we(seg_we),
    .seg_widx(seg_widx), .seg_wbase(seg_wbase), .seg_wlen(seg_wlen),
    .seg_wrights(seg_wrights), .seg_wvalid(seg_wvalid), .pt_we(pt_we),
    .pt_waddr(pt_waddr), .pt_wblock(pt_wblock), .pt_wpresent(pt_wpresent),
    .busy(busy), .done(done), .phys_addr(phys_addr), .fault(fault)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic outs(string tag, bit e_busy, bit e_done, bit [19:0] e_pa, bit [1:0] e_f);
    cmp({tag, " busy"}, 32'(busy), 32'(e_busy));
    cmp({tag, " done"}, 32'(done), 32'(e_done));
    cmp({tag, " phys_addr"}, 32'(phys_addr), 32'(e_pa));
    cmp({tag, " fault"}, 32'(fault), 32'(e_f));
  endtask

  function automatic bit allowed(bit [1:0] rt, bit [1:0] kind, bit sys);
    case (rt)
      2'd0: return 1'b1;
      2'd1: return (kind == 2'd0) || (kind == 2'd3);
      2'd2: return kind == 2'd2;
      default: return sys;
    endcase
  endfunction

  // R10: every table write empties the cache model.
  task automatic seg_load(int idx, bit [9:0] base, bit [8:0] len, bit [1:0] rt, bit ok);
    seg_we = 1'b1; seg_widx = 4'(idx); seg_wbase = base; seg_wlen = len;
    seg_wrights = rt; seg_wvalid = ok;
    @(negedge clk);
    seg_we = 1'b0;
    m_base[idx] = base; m_len[idx] = len; m_rt[idx] = rt; m_ok[idx] = ok;
    cached.delete();
    outs("R10 seg write quiet", 0, 0, 0, 0);
  endtask

  task automatic pt_load(int a, bit [11:0] blk, bit pres);
    pt_we = 1'b1; pt_waddr = 10'(a); pt_wblock = blk; pt_wpresent = pres;
    @(negedge clk);
    pt_we = 1'b0;
    m_blk[a] = blk; m_pres[a] = pres;
    cached.delete();
    outs("R10 pt write quiet", 0, 0, 0, 0);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      outs(tag, 0, 0, 0, 0);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the result.
  task automatic issue(string tag, bit [19:0] a, bit [1:0] kind, bit sys, bit junk);
    int        key, pos, seg, pg;
    bit [9:0]  pta;
    bit [1:0]  ef;
    bit [19:0] epa;
    key = int'(a[19:8]); seg = int'(a[19:16]); pg = int'(a[15:8]);
    pta = m_base[seg] + 10'(pg);
    pos = -1;
    foreach (cached[i]) if (cached[i] == key) pos = i;
    if (pos >= 0) begin
      cached.delete(pos);
      cached.push_front(key);
      ef = allowed(m_rt[seg], kind, sys) ? 2'd0 : 2'd2;
    end else begin
      if (!m_ok[seg])                         ef = 2'd3;
      else if (9'(pg) >= m_len[seg])          ef = 2'd1;
      else if (!allowed(m_rt[seg], kind, sys)) ef = 2'd2;
      else if (!m_pres[pta])                  ef = 2'd3;
      else                                    ef = 2'd0;
      if (ef == 2'd0) begin
        cached.push_front(key);
        if (cached.size() > 8) void'(cached.pop_back());
      end
    end
    epa = (ef == 2'd0) ? {m_blk[pta], a[7:0]} : 20'h0;
    req_valid = 1'b1; req_addr = a; req_kind = kind; req_sys = sys;
    @(negedge clk);
    if (pos >= 0) begin
      req_valid = 1'b0;
      outs({tag, " R3 hit"}, 0, 1, epa, ef);
    end else begin
      outs({tag, " R4 walk1"}, 1, 0, 0, 0);
      if (junk) begin
        req_addr = a ^ 20'h5A5A5; req_kind = 2'd1; req_sys = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      outs({tag, " R4 walk2"}, 1, 0, 0, 0);
      req_valid = 1'b0;
      @(negedge clk);
      outs({tag, " R4 result"}, 0, 1, epa, ef);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_kind = '0; req_sys = 1'b0;
    seg_we = 1'b0; seg_widx = '0; seg_wbase = '0; seg_wlen = '0;
    seg_wrights = '0; seg_wvalid = 1'b0;
    pt_we = 1'b0; pt_waddr = '0; pt_wblock = '0; pt_wpresent = 1'b0;
    for (int i = 0; i < 1024; i++) begin m_blk[i] = '0; m_pres[i] = 1'b0; end
    for (int i = 0; i < 16; i++) m_ok[i] = 1'b0;
    // The page table has no reset: mark every entry absent first.
    repeat (2) @(negedge clk);
    outs("R1 in reset", 0, 0, 0, 0);
    rst = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      pt_we = 1'b1; pt_waddr = 10'(i); pt_wblock = '0; pt_wpresent = 1'b0;
      @(negedge clk);
    end
    pt_we = 1'b0;
    cached.delete();
    idle("R1 after reset", 2);

    // R2 R4: worked translation 6 02 7E -> 019 7E
    seg_load(6, 10'h035, 9'd5, 2'd0, 1'b1);
    pt_load(10'h037, 12'h019, 1'b1);
    pt_load(10'h039, 12'hA61, 1'b1);
    issue("R2 example", 20'h6027E, 2'd0, 1'b0, 1'b0);
    issue("R2 same pair", 20'h60211, 2'd1, 1'b0, 1'b0);
    issue("R2 page4", 20'h604C3, 2'd2, 1'b0, 1'b0);
    // R6 bounds; R9 faults install nothing, so the repeat walks again
    issue("R6 bounds", 20'h60500, 2'd0, 1'b0, 1'b0);
    issue("R9 fault no fill", 20'h60501, 2'd0, 1'b0, 1'b0);
    // R8 invalid segment
    issue("R8 seg invalid", 20'h31234, 2'd0, 1'b0, 1'b0);

    // R7 read-only segment
    seg_load(2, 10'h100, 9'd256, 2'd1, 1'b1);
    pt_load(10'h1FF, 12'h0AB, 1'b1);
    issue("R7 ro read", 20'h2FF01, 2'd0, 1'b0, 1'b0);
    issue("R7 ro write", 20'h2FF02, 2'd1, 1'b0, 1'b0);
    issue("R7 ro fetch", 20'h2FF03, 2'd2, 1'b0, 1'b0);
    issue("R7 ro kind3", 20'h2FF04, 2'd3, 1'b0, 1'b0);
    issue("R8 page absent", 20'h21000, 2'd0, 1'b0, 1'b0);
    // R8 priority: bounds before rights
    seg_load(7, 10'h000, 9'd2, 2'd1, 1'b1);
    issue("R8 bounds over rights", 20'h70300, 2'd1, 1'b0, 1'b0);
    issue("R8 rights over absent", 20'h70100, 2'd1, 1'b0, 1'b0);

    // R5 wrap of base+page, R7 fetch-only
    seg_load(4, 10'h3F0, 9'd64, 2'd2, 1'b1);
    pt_load(10'h010, 12'h5C3, 1'b1);
    issue("R5 wrap fetch", 20'h42080, 2'd2, 1'b0, 1'b0);
    issue("R7 exec read on hit", 20'h42081, 2'd0, 1'b0, 1'b0);
    issue("R7 exec read miss", 20'h40000, 2'd0, 1'b0, 1'b0);

    // R7 system-only
    seg_load(5, 10'h200, 9'd1, 2'd3, 1'b1);
    pt_load(10'h200, 12'hFFF, 1'b1);
    issue("R7 sys denied", 20'h50010, 2'd0, 1'b0, 1'b0);
    issue("R7 sys granted", 20'h50020, 2'd0, 1'b1, 1'b0);
    issue("R7 sys denied hit", 20'h50030, 2'd0, 1'b0, 1'b0);

    // R10 flush: rewrite a mapped entry, the next access walks again
    issue("R10 before", 20'h6027E, 2'd0, 1'b0, 1'b0);
    issue("R10 cached", 20'h6027F, 2'd0, 1'b0, 1'b0);
    pt_load(10'h037, 12'h777, 1'b1);
    issue("R10 after write", 20'h6027E, 2'd0, 1'b0, 1'b0);

    // R9 LRU: fill 8, reuse page 0, a ninth pair evicts page 1
    seg_load(2, 10'h100, 9'd256, 2'd0, 1'b1);
    for (int p = 0; p < 9; p++) pt_load(10'h100 + 10'(p), 12'h300 + 12'(p), 1'b1);
    for (int p = 0; p < 8; p++) issue("R9 fill", {4'h2, 8'(p), 8'h11}, 2'd0, 1'b0, 1'b0);
    issue("R9 reuse p0", 20'h20022, 2'd0, 1'b0, 1'b0);
    issue("R9 ninth", 20'h20833, 2'd0, 1'b0, 1'b0);
    issue("R9 p0 kept", 20'h20044, 2'd0, 1'b0, 1'b0);
    issue("R9 p1 evicted", 20'h20155, 2'd0, 1'b0, 1'b0);
    issue("R9 p3 kept", 20'h20366, 2'd0, 1'b0, 1'b0);

    // R11 requests during a walk are ignored
    issue("R11 busy ignore", 20'h60466, 2'd0, 1'b0, 1'b1);
    idle("R11 no extra done", 2);

    // R12 back-to-back hits, then quiet
    for (int k = 0; k < 4; k++) issue("R12 b2b", {12'h604, 8'(k)}, 2'd0, 1'b0, 1'b0);
    idle("R12 quiet", 2);

    summary();
    $finish;
  end

endmodule